// File: doc/BRIEF.md
# One-Shot Delayed Pulse Timer

This block produces one delayed output pulse for each trigger. A trigger is either a one-cycle software strobe or a chosen edge on an asynchronous input pin. The trigger restarts a 16-bit up-counter from zero. When the count equals the delay compare value, the output goes to its active level and the set interrupt pulses. When the count equals the stop compare value, the release interrupt pulses. The output returns to its inactive level one cycle after that, and the counter stops. The block then waits for the next trigger.

Both compare registers are live. A bus write changes the value that the very next comparison uses, with no shadow copy. Software that lowers a compare value below the running count therefore makes the counter run on through its top value and wrap to zero before the match can happen. A global enable gates the whole sequence, and a polarity bit selects whether the active output level is high or low.

Top module: `oneshot_pulse_timer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, with `out_pol`=1, `pulse_out`, `irq_cc0` and `irq_cc1` are all 0.
- R2: A software trigger sampled at clock edge E restarts the count at zero. `irq_cc1` is high and `pulse_out` is at its active level first in the cycle that follows edge E+D1+1, where D1 is the delay compare value.
- R3: With stop compare value D0 ≥ D1, `irq_cc0` is high first in the cycle after edge E+D0+1, and `pulse_out` returns to its inactive level one cycle later. The active width is therefore D0−D1+1 cycles, and counting stops.
- R4: In a sequence that is not disturbed, each interrupt is high for exactly one cycle.
- R5: `trig_edge_sel` selects the active pin edge: 0 none, 1 rising, 2 falling, 3 both. A pin edge is accepted two cycles later than a software strobe would be, and an unselected edge starts nothing.
- R6: A trigger of either kind that arrives while a sequence is counting is ignored. The timing stays the same and no second pulse follows.
- R7: A compare write lands at the clock edge and is used in the next cycle's comparison. Raising D0 during a run lengthens the pulse to the new D0−D1+1.
- R8: If both compare values are rewritten below the running count, the counter wraps through FFFFH to 0000H. The set interrupt then comes 10000H+D1new+1 cycles after E, and the release interrupt comes 10000H+D0new+1 cycles after E.
- R9: `en`=0 clears the counter, both interrupts and the output (to inactive) at the next edge, and triggers are ignored while `en` is low. After `en` returns to 1 the block stays idle, and the next trigger counts from zero.
- R10: `out_pol`=1 makes the active level high and `out_pol`=0 makes it low. The idle level is the opposite one.
- R11: With D0 = D1, both interrupts fire in the same cycle and the active width is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Timer enable |
| out_pol | input | 1 | Active output level (1 = high) |
| trig_edge_sel | input | 2 | Pin edge select: 0 none, 1 rise, 2 fall, 3 both |
| ext_trig | input | 1 | Asynchronous trigger pin |
| sw_trig | input | 1 | One-cycle software trigger strobe |
| cmp0_we | input | 1 | Write strobe for the stop compare register |
| cmp1_we | input | 1 | Write strobe for the delay compare register |
| cmp_wdata | input | 16 | Compare write data |
| pulse_out | output | 1 | Registered pulse output |
| irq_cc0 | output | 1 | Stop-match interrupt, one cycle |
| irq_cc1 | output | 1 | Delay-match interrupt, one cycle |

## Verification
The assertions check, on every cycle, the relations between the outputs: the output is at its active level whenever the set interrupt fires, it falls to inactive right after the release interrupt, the release interrupt never repeats on the next cycle, and a low enable silences everything by the next edge. The actual delay and width values, wrap-around after a live rewrite, ignored retriggers, edge-select behaviour and the restart from zero after disable all depend on values and history. Only the bench scenarios, which time each pulse from the trigger edge, can show them.

// File: rtl/ost_pkg.sv
package ost_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  localparam int NUM_CMP = 2;
  localparam int CMP_STOP = 0;
  localparam int CMP_SET  = 1;
endpackage

// File: rtl/ost_trig_detect.sv
module ost_trig_detect
  import ost_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_async,
  input  logic [1:0] edge_sel,
  output logic       edge_hit
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         last_q;
  logic         rise;
  logic         fall;
  edge_sel_e    sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], pin_async};
      last_q <= sync_q[MSB];
    end
  end

  assign sel  = edge_sel_e'(edge_sel);
  assign rise = sync_q[MSB] & ~last_q;
  assign fall = ~sync_q[MSB] & last_q;

  always_comb begin
    case (sel)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ost_cmp_bank.sv
module ost_cmp_bank
  import ost_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_CMP-1:0]             wr_en,
  input  logic [CNT_W-1:0]               wr_data,
  output logic [NUM_CMP-1:0][CNT_W-1:0]  cmp_q
);
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst)          cmp_q[i] <= '0;
      else if (wr_en[i]) cmp_q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/ost_seq_core.sv
module ost_seq_core
  import ost_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic [CNT_W-1:0] cmp_stop,
  input  logic [CNT_W-1:0] cmp_set,
  output logic             hit_stop,
  output logic             hit_set,
  output logic             irq_stop,
  output logic             irq_set
);
  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             running;

  assign running  = (st_q == ST_RUN);
  assign hit_stop = running && (cnt_q == cmp_stop);
  assign hit_set  = running && (cnt_q == cmp_set);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      irq_stop <= 1'b0;
      irq_set  <= 1'b0;
    end else begin
      irq_stop <= hit_stop;
      irq_set  <= hit_set;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
          end
        end
        ST_RUN: begin
          if (hit_stop) st_q <= ST_IDLE;
          else          cnt_q <= cnt_q + CNT_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ost_out_stage.sv
module ost_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pol,
  input  logic set_hit,
  input  logic stop_hit,
  output logic pulse_q
);
  logic act_q;
  logic stop_q;
  logic act_n;

  always_comb begin
    act_n = act_q;
    if (stop_q)  act_n = 1'b0;
    if (set_hit) act_n = 1'b1;
    if (!en)     act_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      stop_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      act_q   <= act_n;
      stop_q  <= en & stop_hit;
      pulse_q <= act_n ? pol : ~pol;
    end
  end
endmodule

// File: rtl/oneshot_pulse_timer.sv
module oneshot_pulse_timer
  import ost_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             out_pol,
  input  logic [1:0]       trig_edge_sel,
  input  logic             ext_trig,
  input  logic             sw_trig,
  input  logic             cmp0_we,
  input  logic             cmp1_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic             pulse_out,
  output logic             irq_cc0,
  output logic             irq_cc1
);
  logic                          pin_hit;
  logic                          start;
  logic [NUM_CMP-1:0]            cmp_we;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val;
  logic                          hit_stop;
  logic                          hit_set;

  assign start = pin_hit | sw_trig;
  always_comb begin
    cmp_we           = '0;
    cmp_we[CMP_STOP] = cmp0_we;
    cmp_we[CMP_SET]  = cmp1_we;
  end

  ost_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst(rst), .pin_async(ext_trig),
    .edge_sel(trig_edge_sel), .edge_hit(pin_hit)
  );

  ost_cmp_bank #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .wr_en(cmp_we), .wr_data(cmp_wdata), .cmp_q(cmp_val)
  );

  ost_seq_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .en(en), .start(start),
    .cmp_stop(cmp_val[CMP_STOP]), .cmp_set(cmp_val[CMP_SET]),
    .hit_stop(hit_stop), .hit_set(hit_set),
    .irq_stop(irq_cc0), .irq_set(irq_cc1)
  );

  ost_out_stage u_out (
    .clk(clk), .rst(rst), .en(en), .pol(out_pol),
    .set_hit(hit_set), .stop_hit(hit_stop), .pulse_q(pulse_out)
  );
endmodule

// File: rtl/ost_checker.sv
module ost_checker (
  input logic clk,
  input logic rst,
  input logic en,
  input logic out_pol,
  input logic pulse_out,
  input logic irq_cc0,
  input logic irq_cc1
);
  // R9: disable silences interrupts and forces the inactive level
  a_r9_disable_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!irq_cc0 && !irq_cc1 && (pulse_out == !$past(out_pol))));

  // R2 / R10: the set interrupt coincides with the active level
  a_r2_set_active: assert property (@(posedge clk) disable iff (rst)
    irq_cc1 |-> (pulse_out == $past(out_pol)));

  // R3: the output is inactive on the cycle after the release interrupt
  a_r3_release_inactive: assert property (@(posedge clk) disable iff (rst)
    irq_cc0 |=> (pulse_out == !$past(out_pol)));

  // R4: the release interrupt lasts one cycle, since counting has stopped
  a_r4_release_single: assert property (@(posedge clk) disable iff (rst)
    irq_cc0 |=> !irq_cc0);
endmodule

bind oneshot_pulse_timer ost_checker u_chk (
  .clk(clk), .rst(rst), .en(en), .out_pol(out_pol),
  .pulse_out(pulse_out), .irq_cc0(irq_cc0), .irq_cc1(irq_cc1)
);

// File: tb/oneshot_pulse_timer_tb.sv
module oneshot_pulse_timer_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         out_pol = 1'b1;
  logic [1:0]   trig_edge_sel = 2'd0;
  logic         ext_trig = 1'b0;
  logic         sw_trig = 1'b0;
  logic         cmp0_we = 1'b0;
  logic         cmp1_we = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic         pulse_out;
  logic         irq_cc0;
  logic         irq_cc1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int m_t1, m_t0, m_as, m_ae, m_h1, m_h0;

  always #4 clk = ~clk;

  oneshot_pulse_timer u_dut (
    .clk(clk), .rst(rst), .en(en), .out_pol(out_pol), .trig_edge_sel(trig_edge_sel),
    .ext_trig(ext_trig), .sw_trig(sw_trig), .cmp0_we(cmp0_we), .cmp1_we(cmp1_we),
    .cmp_wdata(cmp_wdata), .pulse_out(pulse_out), .irq_cc0(irq_cc0), .irq_cc1(irq_cc1)
  );

  function automatic int exp_first(int v);          return v + 1;          endfunction
  function automatic int exp_width(int d1, int d0); return d0 - d1 + 1;    endfunction
  function automatic int exp_wrapped(int v);        return (1 << W) + v + 1; endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_cmp(int idx, int val);
    cmp_wdata = W'(val);
    if (idx == 0) cmp0_we = 1'b1; else cmp1_we = 1'b1;
    @(negedge clk);
    cmp0_we = 1'b0;
    cmp1_we = 1'b0;
  endtask

  task automatic fire_sw();
    sw_trig = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fire_ext(logic v);
    ext_trig = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  // sample at negedge n of the cycle count after the trigger edge
  task automatic measure(int limit, logic pol, int inj_at, int kind, int va, int vb);
    m_t1 = -1; m_t0 = -1; m_as = -1; m_ae = -1; m_h1 = 0; m_h0 = 0;
    for (int n = 0; n <= limit; n++) begin
      if (irq_cc1) begin m_h1++; if (m_t1 < 0) m_t1 = n; end
      if (irq_cc0) begin m_h0++; if (m_t0 < 0) m_t0 = n; end
      if ((pulse_out == pol) && m_as < 0) m_as = n;
      if ((pulse_out != pol) && m_as >= 0 && m_ae < 0) m_ae = n;
      sw_trig = 1'b0; cmp0_we = 1'b0; cmp1_we = 1'b0;
      if (n == inj_at) begin
        if (kind == 1) sw_trig = 1'b1;
        if (kind >= 2) begin cmp0_we = 1'b1; cmp_wdata = W'(va); end
      end
      if (n == inj_at + 1 && kind == 3) begin cmp1_we = 1'b1; cmp_wdata = W'(vb); end
      @(negedge clk);
    end
    sw_trig = 1'b0; cmp0_we = 1'b0; cmp1_we = 1'b0;
  endtask

  task automatic check_seq(string tag, int e1, int e0, int wid);
    chk({tag, " set irq time"}, m_t1, e1);
    chk({tag, " release irq time"}, m_t0, e0);
    chk({tag, " active start"}, m_as, e1);
    chk({tag, " active width"}, m_ae - m_as, wid);
    chk({tag, " R4 set irq cycles"}, m_h1, 1);
    chk({tag, " R4 release irq cycles"}, m_h0, 1);
  endtask

  task automatic idle_quiet(string tag, int cycles);
    int seen = 0;
    for (int n = 0; n < cycles; n++) begin
      if (irq_cc0 || irq_cc1 || (pulse_out == out_pol)) seen++;
      sw_trig = 1'b0;
      @(negedge clk);
    end
    chk(tag, seen, 0);
  endtask

  task automatic run_sw(string tag, int d1, int d0);
    wr_cmp(1, d1); wr_cmp(0, d0);
    fire_sw();
    measure(d0 + 20, out_pol, -1, 0, 0, 0);
    check_seq(tag, exp_first(d1), exp_first(d0), exp_width(d1, d0));
  endtask

  task automatic run_ext(string tag, logic v, int d1, int d0);
    wr_cmp(1, d1); wr_cmp(0, d0);
    fire_ext(v);
    measure(d0 + 20, out_pol, -1, 0, 0, 0);
    check_seq(tag, exp_first(d1), exp_first(d0), exp_width(d1, d0));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 pulse_out in reset", int'(pulse_out), 0);
    chk("R1 irq_cc0 in reset", int'(irq_cc0), 0);
    chk("R1 irq_cc1 in reset", int'(irq_cc1), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pulse_out after reset", int'(pulse_out), 0);
    chk("R1 irqs after reset", int'(irq_cc0 | irq_cc1), 0);
    en = 1'b1;
    @(negedge clk);

    run_sw("R2 R3 software trigger", 10, 30);
    run_sw("R11 equal compares", 15, 15);
    run_sw("R2 zero delay", 0, 7);

    out_pol = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 idle level active-low", int'(pulse_out), 1);
    run_sw("R10 active-low pulse", 5, 12);
    out_pol = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 idle level active-high", int'(pulse_out), 0);

    wr_cmp(1, 20); wr_cmp(0, 60);
    fire_sw();
    measure(200, 1'b1, 30, 1, 0, 0);
    check_seq("R6 retrigger ignored", exp_first(20), exp_first(60), exp_width(20, 60));

    wr_cmp(1, 10); wr_cmp(0, 40);
    fire_sw();
    measure(120, 1'b1, 20, 2, 80, 0);
    check_seq("R7 live stop raise", exp_first(10), exp_first(80), exp_width(10, 80));

    wr_cmp(1, 4); wr_cmp(0, 9);
    trig_edge_sel = 2'd0;
    ext_trig = 1'b1; idle_quiet("R5 none ignores rise", 50);
    ext_trig = 1'b0; idle_quiet("R5 none ignores fall", 50);
    trig_edge_sel = 2'd1;
    run_ext("R5 rising edge", 1'b1, 4, 9);
    ext_trig = 1'b0; idle_quiet("R5 rising mode ignores fall", 50);
    trig_edge_sel = 2'd2;
    ext_trig = 1'b1; idle_quiet("R5 falling mode ignores rise", 50);
    run_ext("R5 falling edge", 1'b0, 4, 9);
    trig_edge_sel = 2'd3;
    run_ext("R5 both rise", 1'b1, 6, 11);
    run_ext("R5 both fall", 1'b0, 6, 11);

    wr_cmp(1, 30); wr_cmp(0, 100);
    fire_sw();
    repeat (60) @(negedge clk);
    chk("R9 active before disable", int'(pulse_out), 1);
    en = 1'b0;
    @(negedge clk);
    chk("R9 disable forces inactive", int'(pulse_out), 0);
    sw_trig = 1'b1;
    idle_quiet("R9 trigger ignored while disabled", 100);
    en = 1'b1;
    idle_quiet("R9 idle after re-enable", 200);
    run_sw("R9 restart from zero", 30, 100);

    wr_cmp(1, 1000); wr_cmp(0, 3000);
    fire_sw();
    measure((1 << W) + 260, 1'b1, 500, 3, 200, 100);
    check_seq("R8 wrap after lowering", exp_wrapped(100), exp_wrapped(200), exp_width(100, 200));

    for (int it = 0; it < 16; it++) begin
      int d1 = $urandom_range(0, 150);
      int d0 = d1 + $urandom_range(0, 150);
      out_pol = 1'($urandom_range(0, 1));
      repeat (3) @(negedge clk);
      chk("R10 random idle level", int'(pulse_out), int'(!out_pol));
      if ($urandom_range(0, 1) == 1) run_sw("R2 R3 random software", d1, d0);
      else run_ext("R5 R3 random pin", !ext_trig, d1, d0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule